// File: doc/BRIEF.md
# Flash Array Write-Protection Controller

This block keeps the protection portion of a serial flash status register and rules on every program or erase aimed at the memory array. A status-register write presents a data byte. The block copies the protection field and a sticky lock bit out of that byte. It does so only when the active-low write-protect pin and the lock allow it.

A program or erase request carries a 19-bit address and an operation kind. The kinds are byte program, 4 KB sector erase, 64 KB block erase and chip erase. The block answers each request with a single-cycle grant or deny pulse one clock later. The protected region always ends at the top of the array. A three-bit level selects how far down from the top it reaches, and a fourth bit is stored but plays no part in the address decode. Chip erase is allowed only when the whole four-bit field reads zero. The serial shifter, write-enable latch, busy state and array timing lie outside this block.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: Reset sets the protection field to 4'b1111 and the lock bit to 0, with grant and deny both low.
- R2: A status write takes the protection field from data bits [5:2] and the lock from data bit 7 whenever the pin is high or the lock is 0, with the new values visible one cycle after the write.
- R3: A status write made while the pin is low and the lock is 1 leaves the protection field and the lock unchanged.
- R4: While the pin is high, a held lock value of 1 does not block a status write.
- R5: Field bits [2:0] select the protected region: 000 protects nothing, 001 protects 0x70000-0x7FFFF, 010 protects 0x60000-0x7FFFF, 011 protects 0x40000-0x7FFFF, and any value with bit 2 set protects 0x00000-0x7FFFF.
- R6: Field bit 3 has no effect on the protected region.
- R7: A byte program (kind 0) is denied exactly when its address lies in the protected region.
- R8: A sector erase (kind 1, 4 KB) or block erase (kind 2, 64 KB) is denied exactly when the aligned range starting at the address with its low 12 or 16 bits cleared overlaps the protected region.
- R9: A chip erase (kind 3) is granted only when all four protection bits are 0.
- R10: Each request cycle on the request strobe produces exactly one single-cycle pulse, either grant or deny and never both, in the following cycle; no pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_wr | input | 1 | Status-register write strobe |
| sr_din | input | 8 | Status data byte (lock at bit 7, protection field at bits 5:2) |
| wp_n | input | 1 | Active-low write-protect pin, sampled with sr_wr |
| op_vld | input | 1 | Program/erase request strobe |
| op_kind | input | 2 | 0 byte program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | 19 | Request address |
| bp_out | output | 4 | Current protection field |
| lock_out | output | 1 | Current lock bit |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |

## Verification
The assertions assume that op_kind holds one of the four defined codes whenever op_vld is high. They also assume that sr_din and wp_n are settled on the same clock edge that samples sr_wr, because the lock check and the field capture both use that edge. The stimulus changes every input only on the falling clock edge, uses only the four kind codes, and drives the pin together with the write strobe. The properties therefore always see stable, legal inputs.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;

   typedef enum logic [1:0] {
      OP_BYTE   = 2'd0,
      OP_SECTOR = 2'd1,
      OP_BLOCK  = 2'd2,
      OP_CHIP   = 2'd3
   } op_kind_e;

   localparam int STAT_W   = 8;
   localparam int LOCK_POS = 7;
   localparam int BP_LSB   = 2;
   localparam int BP_W     = 4;
   localparam int LVL_W    = 3;

   typedef struct packed {
      logic            lock;
      logic [BP_W-1:0] bp;
   } prot_state_t;

endpackage

// File: rtl/prot_state_reg.sv
module prot_state_reg
   import flash_wprot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_wr,
   input  logic [STAT_W-1:0] sr_din,
   input  logic              wp_n,
   output prot_state_t       state
);

   localparam logic [BP_W-1:0] BP_RESET = '1;

   prot_state_t state_q;
   logic        wr_allowed;

   // Pin is taken in the same cycle as the strobe; lock only bites when pin is low.
   assign wr_allowed = sr_wr && (wp_n || !state_q.lock);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q.bp   <= BP_RESET;
         state_q.lock <= 1'b0;
      end else if (wr_allowed) begin
         state_q.bp   <= sr_din[BP_LSB +: BP_W];
         state_q.lock <= sr_din[LOCK_POS];
      end
   end

   assign state = state_q;

endmodule

// File: rtl/prot_range_dec.sv
module prot_range_dec
   import flash_wprot_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic [BP_W-1:0]   bp,
   output logic              any_prot,
   output logic [ADDR_W-1:0] prot_lo
);

   localparam int NLVL = (1 << (LVL_W - 1));   // levels 0..3 are partial
   localparam int FRAC_BASE = ADDR_W - NLVL;   // level k protects 2^(FRAC_BASE+k)

   if (ADDR_W < NLVL + 1) begin : g_bad_width
      $error("prot_range_dec: ADDR_W too small for level decode");
   end

   logic [ADDR_W-1:0] lo_tab [NLVL];

   for (genvar k = 0; k < NLVL; k++) begin : g_lvl
      if (k == 0) begin : g_none
         assign lo_tab[k] = '1;
      end else begin : g_frac
         assign lo_tab[k] = {ADDR_W{1'b1}} << (FRAC_BASE + k);
      end
   end

   // Field bit 3 is stored only; the decode looks at bits [2:0].
   always_comb begin
      if (bp[LVL_W-1]) begin
         any_prot = 1'b1;
         prot_lo  = '0;
      end else begin
         any_prot = (bp[LVL_W-2:0] != '0);
         prot_lo  = lo_tab[bp[LVL_W-2:0]];
      end
   end

endmodule

// File: rtl/prot_access_chk.sv
module prot_access_chk
   import flash_wprot_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int SECT_LOG2 = 12,
   parameter int BLK_LOG2  = 16
) (
   input  op_kind_e          kind,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BP_W-1:0]   bp,
   input  logic              any_prot,
   input  logic [ADDR_W-1:0] prot_lo,
   output logic              refuse
);

   localparam int NSPAN = 3;
   localparam int SPAN_LOG2 [NSPAN] = '{0, SECT_LOG2, BLK_LOG2};

   if (SECT_LOG2 < 1 || SECT_LOG2 >= BLK_LOG2) begin : g_bad_sect
      $error("prot_access_chk: sector size must be below block size");
   end
   if (BLK_LOG2 >= ADDR_W) begin : g_bad_blk
      $error("prot_access_chk: block size must be below array size");
   end

   // Last address touched by each span kind: low bits forced to one.
   logic [ADDR_W-1:0] span_end [NSPAN];

   for (genvar s = 0; s < NSPAN; s++) begin : g_span
      localparam logic [ADDR_W-1:0] MASK = (ADDR_W'(1) << SPAN_LOG2[s]) - ADDR_W'(1);
      assign span_end[s] = addr | MASK;
   end

   // The protected region always reaches the top, so overlap means end >= low bound.
   always_comb begin
      unique case (kind)
         OP_BYTE:   refuse = any_prot && (span_end[0] >= prot_lo);
         OP_SECTOR: refuse = any_prot && (span_end[1] >= prot_lo);
         OP_BLOCK:  refuse = any_prot && (span_end[2] >= prot_lo);
         OP_CHIP:   refuse = (bp != '0);
         default:   refuse = 1'b1;
      endcase
   end

endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
   import flash_wprot_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int SECT_LOG2 = 12,
   parameter int BLK_LOG2  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_wr,
   input  logic [7:0]        sr_din,
   input  logic              wp_n,
   input  logic              op_vld,
   input  logic [1:0]        op_kind,
   input  logic [ADDR_W-1:0] op_addr,
   output logic [3:0]        bp_out,
   output logic              lock_out,
   output logic              grant,
   output logic              deny
);

   if (STAT_W != 8 || BP_W != 4) begin : g_bad_pkg
      $error("flash_wprot_ctrl: port widths assume an 8-bit status byte");
   end

   prot_state_t       st;
   logic              any_prot;
   logic [ADDR_W-1:0] prot_lo;
   logic              refuse;
   logic              grant_q;
   logic              deny_q;

   prot_state_reg u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .sr_wr  (sr_wr),
      .sr_din (sr_din),
      .wp_n   (wp_n),
      .state  (st)
   );

   prot_range_dec #(.ADDR_W(ADDR_W)) u_dec (
      .bp       (st.bp),
      .any_prot (any_prot),
      .prot_lo  (prot_lo)
   );

   prot_access_chk #(
      .ADDR_W    (ADDR_W),
      .SECT_LOG2 (SECT_LOG2),
      .BLK_LOG2  (BLK_LOG2)
   ) u_chk (
      .kind     (op_kind_e'(op_kind)),
      .addr     (op_addr),
      .bp       (st.bp),
      .any_prot (any_prot),
      .prot_lo  (prot_lo),
      .refuse   (refuse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
      end else begin
         grant_q <= op_vld && !refuse;
         deny_q  <= op_vld && refuse;
      end
   end

   assign bp_out   = st.bp;
   assign lock_out = st.lock;
   assign grant    = grant_q;
   assign deny     = deny_q;

endmodule

// File: rtl/flash_wprot_chk.sv
module flash_wprot_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sr_wr,
   input logic [7:0]        sr_din,
   input logic              wp_n,
   input logic              op_vld,
   input logic [1:0]        op_kind,
   input logic [ADDR_W-1:0] op_addr,
   input logic [3:0]        bp_out,
   input logic              lock_out,
   input logic              grant,
   input logic              deny
);

   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && deny)); // R10

   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld |=> (grant ^ deny)); // R10

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> (!grant && !deny)); // R10

   AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && (wp_n || !lock_out)) |=>
         (bp_out == $past(sr_din[5:2]) && lock_out == $past(sr_din[7]))); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !sr_wr |=> ($stable(bp_out) && $stable(lock_out))); // R2

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && !wp_n && lock_out) |=> ($stable(bp_out) && $stable(lock_out))); // R3

   AST_PIN_HIGH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && wp_n && lock_out) |=> (bp_out == $past(sr_din[5:2]))); // R4

   AST_FULL_PROT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && bp_out[2]) |=> deny); // R5

   AST_OPEN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op_kind == 2'd0 && bp_out[2:0] == 3'b000) |=> grant); // R7

   AST_CHIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op_kind == 2'd3) |=> (grant == ($past(bp_out) == 4'b0000))); // R9

endmodule

bind flash_wprot_ctrl flash_wprot_chk #(.ADDR_W(ADDR_W)) u_wprot_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sr_wr    (sr_wr),
   .sr_din   (sr_din),
   .wp_n     (wp_n),
   .op_vld   (op_vld),
   .op_kind  (op_kind),
   .op_addr  (op_addr),
   .bp_out   (bp_out),
   .lock_out (lock_out),
   .grant    (grant),
   .deny     (deny)
);

// File: tb/tb_flash_wprot_ctrl.sv
module tb_flash_wprot_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_wr = 1'b0;
   logic [7:0]  sr_din = '0;
   logic        wp_n = 1'b1;
   logic        op_vld = 1'b0;
   logic [1:0]  op_kind = '0;
   logic [18:0] op_addr = '0;
   logic [3:0]  bp_out;
   logic        lock_out;
   logic        grant;
   logic        deny;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   flash_wprot_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sr_wr(sr_wr), .sr_din(sr_din), .wp_n(wp_n),
      .op_vld(op_vld), .op_kind(op_kind), .op_addr(op_addr),
      .bp_out(bp_out), .lock_out(lock_out), .grant(grant), .deny(deny)
   );

   // {bp[3:0], kind[1:0], addr[18:0], expect_deny}
   localparam int NV = 18;
   localparam logic [25:0] VEC [NV] = '{
      {4'b0000, 2'd0, 19'h7FFFF, 1'b0},   // R7 nothing protected
      {4'b0000, 2'd3, 19'h00000, 1'b0},   // R9 chip open
      {4'b0001, 2'd0, 19'h70000, 1'b1},   // R5 R7
      {4'b0001, 2'd0, 19'h6FFFF, 1'b0},   // R7
      {4'b0001, 2'd1, 19'h6F000, 1'b0},   // R8
      {4'b0001, 2'd2, 19'h60000, 1'b0},   // R8
      {4'b0001, 2'd2, 19'h7ABCD, 1'b1},   // R8
      {4'b0010, 2'd1, 19'h60000, 1'b1},   // R5 R8
      {4'b0010, 2'd1, 19'h5FFFF, 1'b0},   // R8
      {4'b0011, 2'd2, 19'h3FFFF, 1'b0},   // R8
      {4'b0011, 2'd2, 19'h40000, 1'b1},   // R5 R8
      {4'b0011, 2'd0, 19'h3FFFF, 1'b0},   // R7
      {4'b0100, 2'd0, 19'h00000, 1'b1},   // R5
      {4'b0111, 2'd1, 19'h00123, 1'b1},   // R5
      {4'b1000, 2'd0, 19'h7FFFF, 1'b0},   // R6
      {4'b1000, 2'd3, 19'h00000, 1'b1},   // R9
      {4'b1001, 2'd0, 19'h6FFFF, 1'b0},   // R6
      {4'b0001, 2'd3, 19'h00000, 1'b1}    // R9
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sr_write(input logic lock, input logic [3:0] bp, input logic pin);
      @(negedge clk);
      sr_wr  = 1'b1;
      sr_din = {lock, 1'b0, bp, 2'b00};
      wp_n   = pin;
      @(negedge clk);
      sr_wr  = 1'b0;
      wp_n   = 1'b1;
   endtask

   task automatic request(input string req, input logic [1:0] kind,
                          input logic [18:0] addr, input logic exp_deny);
      @(negedge clk);
      op_vld  = 1'b1;
      op_kind = kind;
      op_addr = addr;
      @(negedge clk);
      op_vld = 1'b0;
      check(req, {30'd0, grant, deny}, {30'd0, !exp_deny, exp_deny});
      @(negedge clk);
      check("R10 pulse ends", {30'd0, grant, deny}, 32'd0);
   endtask

   initial begin
      #(8 * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 bp", 32'(bp_out), 32'hF);
      check("R1 lock", 32'(lock_out), 32'h0);
      check("R1 pulses", {30'd0, grant, deny}, 32'd0);
      request("R1 byte at 0 after reset", 2'd0, 19'h00000, 1'b1);
      request("R1 chip after reset", 2'd3, 19'h00000, 1'b1);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         sr_write(1'b0, VEC[i][25:22], 1'b1);
         check("R2 field load", 32'(bp_out), 32'(VEC[i][25:22]));
         request($sformatf("R5-table vec %0d", i), VEC[i][21:20], VEC[i][19:1], VEC[i][0]);
      end

      // Lock and pin interplay
      sr_write(1'b1, 4'b0011, 1'b1);
      check("R2 lock set", {27'd0, lock_out, bp_out}, {27'd0, 1'b1, 4'b0011});
      sr_write(1'b0, 4'b0000, 1'b0);
      check("R3 frozen", {27'd0, lock_out, bp_out}, {27'd0, 1'b1, 4'b0011});
      request("R3 still protected", 2'd0, 19'h40000, 1'b1);
      sr_write(1'b1, 4'b0000, 1'b1);
      check("R4 pin high opens", {27'd0, lock_out, bp_out}, {27'd0, 1'b1, 4'b0000});
      sr_write(1'b0, 4'b0111, 1'b0);
      check("R3 frozen again", {27'd0, lock_out, bp_out}, {27'd0, 1'b1, 4'b0000});
      request("R9 chip after frozen", 2'd3, 19'h00000, 1'b0);
      sr_write(1'b0, 4'b0001, 1'b1);
      check("R4 lock cleared", {27'd0, lock_out, bp_out}, {27'd0, 1'b0, 4'b0001});
      sr_write(1'b0, 4'b0010, 1'b0);
      check("R2 pin low lock 0", {27'd0, lock_out, bp_out}, {27'd0, 1'b0, 4'b0010});
      request("R8 sector below 1/4", 2'd1, 19'h5F800, 1'b0);

      // Back-to-back requests
      @(negedge clk);
      op_vld = 1'b1; op_kind = 2'd0; op_addr = 19'h60000;
      @(negedge clk);
      check("R10 first of pair", {30'd0, grant, deny}, 32'd1);
      op_addr = 19'h10000;
      @(negedge clk);
      op_vld = 1'b0;
      check("R10 second of pair", {30'd0, grant, deny}, 32'd2);
      @(negedge clk);
      check("R10 idle after pair", {30'd0, grant, deny}, 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule